// File: doc/BRIEF.md
# DMA Test Control Register

This block is an 8-bit read/write test register that sits next to a DMA engine's 32-bit next-address pointer and 24-bit byte counter. Test software uses it to move the pointer and the counter by one position without running a transfer. It can also select which FIFO depth figure the engine reports, and it can force the transfer direction flag.

Writing a 1 to either of the two stepping strobes schedules a single step. The strobe then clears itself without any further write. The direction flag is never written directly. A separate master bit chooses whether a direction pulse sets the flag or clears it. The remaining fields are plain storage that reads back as written. The pointer and the counter can also be loaded directly through their own load ports.

Top module: `dma_test_ctl`

## Requirements
- R1: After a synchronous reset, `rd_data` is 0x00, `dma_wr` is 0, `fifo_depth` is 88, and `next_addr` and `byte_cnt` are 0.
- R2: A write is a cycle with both `reg_sel` and `reg_wr` high. It stores bit 5 (size), bit 4 (master), bit 2 (burst) and bits 1:0 (offset), and these read back in the same positions. A cycle with `reg_wr` high but `reg_sel` low changes nothing.
- R3: A write with bit 7 set adds 1 (modulo 2^32) to `next_addr` on the clock edge after the write edge. Bit 7 always reads back as 0.
- R4: A write with bit 6 set subtracts 1 from `byte_cnt` on the clock edge after the write edge. A step from 0 wraps to 0xFFFFFF. Bit 6 always reads back as 0.
- R5: `fifo_depth` is 88 while the size bit (bit 5) is 0 and 536 while it is 1. It changes on the write edge.
- R6: A write with bit 3 set drives `dma_wr` to the value of the master bit on the write edge. A write with bit 3 clear leaves `dma_wr` unchanged. `dma_wr` = 1 means data moves from the SCSI side to the host side; 0 means host side to SCSI side.
- R7: When one write carries both a new master value and a direction pulse, `dma_wr` takes the master value held before that write.
- R8: Bit 3 of `rd_data` always shows the current `dma_wr`, not the last pulse value that was written.
- R9: `addr_load` and `cnt_load` load their values on the edge where they are sampled high. A load takes priority over a step that falls due on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_sel | input | 1 | Register select from the bus decode |
| reg_wr | input | 1 | Write enable |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Register read view |
| addr_load | input | 1 | Load enable for the next-address pointer |
| addr_load_val | input | 32 | Load value for the pointer |
| cnt_load | input | 1 | Load enable for the byte counter |
| cnt_load_val | input | 24 | Load value for the counter |
| next_addr | output | 32 | Next-address pointer |
| byte_cnt | output | 24 | Byte counter |
| dma_wr | output | 1 | Transfer direction flag |
| fifo_depth | output | 10 | Reported FIFO depth in bytes |

## Verification
The assertions assume the following about the inputs:
- Reset is held high for at least two edges before any write.
- Reset is not pulsed between a stepping write and the step it schedules.
- Every control input is known at each sampling edge.

The direction properties rely on `rd_data` bit 4 before the edge being the master value used for the pulse. This holds only because the master bit changes solely on a register write.

The bench keeps within these assumptions:
- It drives every input on the falling edge.
- It holds each write for exactly one cycle.
- It issues each load one full cycle after the write whose step it races.

// File: rtl/dma_tc_pkg.sv
package dma_tc_pkg;
  localparam int BIT_ASTEP  = 7;
  localparam int BIT_CSTEP  = 6;
  localparam int BIT_SIZE   = 5;
  localparam int BIT_MASTER = 4;
  localparam int BIT_DIR    = 3;
  localparam int BIT_BURST  = 2;
  localparam int OFFS_W     = 2;

  typedef struct packed {
    logic              size;
    logic              master;
    logic              burst;
    logic [OFFS_W-1:0] offs;
  } ctl_fields_t;
endpackage

// File: rtl/dma_tc_regfile.sv
module dma_tc_regfile
  import dma_tc_pkg::*;
#(
  parameter int DEPTH_W     = 10,
  parameter int DEPTH_SMALL = 88,
  parameter int DEPTH_LARGE = 536
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [7:0]         wr_data,
  output logic [7:0]         rd_data,
  output logic               addr_step,
  output logic               cnt_step,
  output logic               dir,
  output logic [DEPTH_W-1:0] depth
);
  localparam logic [DEPTH_W-1:0] D_S = DEPTH_W'(DEPTH_SMALL);
  localparam logic [DEPTH_W-1:0] D_L = DEPTH_W'(DEPTH_LARGE);

  ctl_fields_t ctl;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl       <= '0;
      addr_step <= 1'b0;
      cnt_step  <= 1'b0;
      dir       <= 1'b0;
      depth     <= D_S;
    end else begin
      // strobes live one cycle only, then drop without a write
      addr_step <= wr_en & wr_data[BIT_ASTEP];
      cnt_step  <= wr_en & wr_data[BIT_CSTEP];
      if (wr_en) begin
        ctl.size   <= wr_data[BIT_SIZE];
        ctl.master <= wr_data[BIT_MASTER];
        ctl.burst  <= wr_data[BIT_BURST];
        ctl.offs   <= wr_data[OFFS_W-1:0];
        depth      <= wr_data[BIT_SIZE] ? D_L : D_S;
        // pulse uses the master value held before this write
        if (wr_data[BIT_DIR]) dir <= ctl.master;
      end
    end
  end

  always_comb begin
    rd_data               = '0;
    rd_data[BIT_SIZE]     = ctl.size;
    rd_data[BIT_MASTER]   = ctl.master;
    rd_data[BIT_DIR]      = dir;
    rd_data[BIT_BURST]    = ctl.burst;
    rd_data[OFFS_W-1:0]   = ctl.offs;
  end
endmodule

// File: rtl/dma_tc_stepper.sv
module dma_tc_stepper #(
  parameter int WIDTH    = 24,
  parameter bit COUNT_UP = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [WIDTH-1:0] load_val,
  input  logic             step,
  output logic [WIDTH-1:0] value
);
  logic [WIDTH-1:0] stepped;

  generate
    if (COUNT_UP) begin : g_up
      assign stepped = value + WIDTH'(1);
    end else begin : g_down
      assign stepped = value - WIDTH'(1);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)       value <= '0;
    else if (load) value <= load_val;
    else if (step) value <= stepped;
  end
endmodule

// File: rtl/dma_test_ctl.sv
module dma_test_ctl #(
  parameter int ADDR_W      = 32,
  parameter int CNT_W       = 24,
  parameter int DEPTH_W     = 10,
  parameter int DEPTH_SMALL = 88,
  parameter int DEPTH_LARGE = 536
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_sel,
  input  logic               reg_wr,
  input  logic [7:0]         wr_data,
  output logic [7:0]         rd_data,
  input  logic               addr_load,
  input  logic [ADDR_W-1:0]  addr_load_val,
  input  logic               cnt_load,
  input  logic [CNT_W-1:0]   cnt_load_val,
  output logic [ADDR_W-1:0]  next_addr,
  output logic [CNT_W-1:0]   byte_cnt,
  output logic               dma_wr,
  output logic [DEPTH_W-1:0] fifo_depth
);
  logic wr_en;
  logic addr_step;
  logic cnt_step;

  assign wr_en = reg_sel & reg_wr;

  dma_tc_regfile #(
    .DEPTH_W(DEPTH_W), .DEPTH_SMALL(DEPTH_SMALL), .DEPTH_LARGE(DEPTH_LARGE)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .addr_step(addr_step), .cnt_step(cnt_step), .dir(dma_wr), .depth(fifo_depth)
  );

  dma_tc_stepper #(.WIDTH(ADDR_W), .COUNT_UP(1'b1)) u_addr (
    .clk(clk), .rst(rst), .load(addr_load), .load_val(addr_load_val),
    .step(addr_step), .value(next_addr)
  );

  dma_tc_stepper #(.WIDTH(CNT_W), .COUNT_UP(1'b0)) u_cnt (
    .clk(clk), .rst(rst), .load(cnt_load), .load_val(cnt_load_val),
    .step(cnt_step), .value(byte_cnt)
  );
endmodule

// File: rtl/dma_test_ctl_chk.sv
module dma_test_ctl_chk #(
  parameter int ADDR_W      = 32,
  parameter int CNT_W       = 24,
  parameter int DEPTH_W     = 10,
  parameter int DEPTH_SMALL = 88,
  parameter int DEPTH_LARGE = 536
) (
  input logic               clk,
  input logic               rst,
  input logic               reg_sel,
  input logic               reg_wr,
  input logic [7:0]         wr_data,
  input logic [7:0]         rd_data,
  input logic               addr_load,
  input logic [ADDR_W-1:0]  addr_load_val,
  input logic               cnt_load,
  input logic [CNT_W-1:0]   cnt_load_val,
  input logic [ADDR_W-1:0]  next_addr,
  input logic [CNT_W-1:0]   byte_cnt,
  input logic               dma_wr,
  input logic [DEPTH_W-1:0] fifo_depth
);
  logic wr;
  assign wr = reg_sel && reg_wr;

  a_r3_addr_step: assert property (@(posedge clk) disable iff (rst)
    ($past(wr && wr_data[7], 2) && !$past(rst) && !$past(addr_load))
      |-> next_addr == $past(next_addr) + ADDR_W'(1));

  a_r4_cnt_step: assert property (@(posedge clk) disable iff (rst)
    ($past(wr && wr_data[6], 2) && !$past(rst) && !$past(cnt_load))
      |-> byte_cnt == $past(byte_cnt) - CNT_W'(1));

  a_r3_strobes_read_zero: assert property (@(posedge clk) disable iff (rst)
    rd_data[7:6] == 2'b00);

  a_r5_depth: assert property (@(posedge clk) disable iff (rst)
    fifo_depth == (rd_data[5] ? DEPTH_W'(DEPTH_LARGE) : DEPTH_W'(DEPTH_SMALL)));

  a_r7_dir_pulse: assert property (@(posedge clk) disable iff (rst)
    (wr && wr_data[3]) |=> dma_wr == $past(rd_data[4]));

  a_r6_dir_hold: assert property (@(posedge clk) disable iff (rst)
    !(wr && wr_data[3]) |=> $stable(dma_wr));

  a_r8_dir_readback: assert property (@(posedge clk) disable iff (rst)
    rd_data[3] == dma_wr);

  a_r9_addr_load: assert property (@(posedge clk) disable iff (rst)
    addr_load |=> next_addr == $past(addr_load_val));

  a_r9_cnt_load: assert property (@(posedge clk) disable iff (rst)
    cnt_load |=> byte_cnt == $past(cnt_load_val));
endmodule

bind dma_test_ctl dma_test_ctl_chk #(
  .ADDR_W(ADDR_W), .CNT_W(CNT_W), .DEPTH_W(DEPTH_W),
  .DEPTH_SMALL(DEPTH_SMALL), .DEPTH_LARGE(DEPTH_LARGE)
) u_chk (
  .clk(clk), .rst(rst), .reg_sel(reg_sel), .reg_wr(reg_wr), .wr_data(wr_data),
  .rd_data(rd_data), .addr_load(addr_load), .addr_load_val(addr_load_val),
  .cnt_load(cnt_load), .cnt_load_val(cnt_load_val), .next_addr(next_addr),
  .byte_cnt(byte_cnt), .dma_wr(dma_wr), .fifo_depth(fifo_depth)
);

// File: tb/dma_test_ctl_tb.sv
module dma_test_ctl_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_sel = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  wr_data = '0;
  logic [7:0]  rd_data;
  logic        addr_load = 1'b0;
  logic [31:0] addr_load_val = '0;
  logic        cnt_load = 1'b0;
  logic [23:0] cnt_load_val = '0;
  logic [31:0] next_addr;
  logic [23:0] byte_cnt;
  logic        dma_wr;
  logic [9:0]  fifo_depth;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_test_ctl u_dut (
    .clk(clk), .rst(rst), .reg_sel(reg_sel), .reg_wr(reg_wr), .wr_data(wr_data),
    .rd_data(rd_data), .addr_load(addr_load), .addr_load_val(addr_load_val),
    .cnt_load(cnt_load), .cnt_load_val(cnt_load_val), .next_addr(next_addr),
    .byte_cnt(byte_cnt), .dma_wr(dma_wr), .fifo_depth(fifo_depth)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // write held for one cycle; returns at the falling edge after the write edge
  task automatic wr_reg(input logic [7:0] d, input logic sel = 1'b1);
    @(negedge clk);
    reg_sel = sel; reg_wr = 1'b1; wr_data = d;
    @(negedge clk);
    reg_sel = 1'b0; reg_wr = 1'b0; wr_data = '0;
  endtask

  task automatic load_addr(input logic [31:0] v);
    @(negedge clk); addr_load = 1'b1; addr_load_val = v;
    @(negedge clk); addr_load = 1'b0;
  endtask

  task automatic load_cnt(input logic [23:0] v);
    @(negedge clk); cnt_load = 1'b1; cnt_load_val = v;
    @(negedge clk); cnt_load = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 rd_data", 32'(rd_data), 32'h0);
    chk("R1 dma_wr", 32'(dma_wr), 32'h0);
    chk("R1 fifo_depth", 32'(fifo_depth), 32'd88);
    chk("R1 next_addr", next_addr, 32'h0);
    chk("R1 byte_cnt", 32'(byte_cnt), 32'h0);
  endtask

  task automatic t_fields;
    wr_reg(8'h27);
    chk("R2 readback", 32'(rd_data), 32'h27);
    chk("R5 depth large", 32'(fifo_depth), 32'd536);
    wr_reg(8'h00, 1'b0);
    chk("R2 unselected ignored", 32'(rd_data), 32'h27);
    chk("R5 unselected depth", 32'(fifo_depth), 32'd536);
    wr_reg(8'h01);
    chk("R2 offset only", 32'(rd_data), 32'h01);
    chk("R5 depth small", 32'(fifo_depth), 32'd88);
  endtask

  task automatic t_addr;
    load_addr(32'h0000_1000);
    chk("R9 addr load", next_addr, 32'h0000_1000);
    wr_reg(8'h80);
    chk("R3 strobe reads 0", 32'(rd_data), 32'h0);
    chk("R3 no step yet", next_addr, 32'h0000_1000);
    @(negedge clk);
    chk("R3 stepped", next_addr, 32'h0000_1001);
    @(negedge clk);
    chk("R3 single step", next_addr, 32'h0000_1001);
    load_addr(32'hFFFF_FFFF);
    wr_reg(8'h80);
    @(negedge clk);
    chk("R3 wrap", next_addr, 32'h0);
  endtask

  task automatic t_cnt;
    load_cnt(24'd5);
    chk("R9 cnt load", 32'(byte_cnt), 32'd5);
    wr_reg(8'h40);
    chk("R4 strobe reads 0", 32'(rd_data), 32'h0);
    @(negedge clk);
    chk("R4 decrement", 32'(byte_cnt), 32'd4);
    load_cnt(24'd0);
    wr_reg(8'h40);
    @(negedge clk);
    chk("R4 wrap", 32'(byte_cnt), 32'h00FF_FFFF);
  endtask

  task automatic t_dir;
    wr_reg(8'h10);
    chk("R6 master alone", 32'(dma_wr), 32'h0);
    wr_reg(8'h18);
    chk("R6 set", 32'(dma_wr), 32'h1);
    chk("R8 readback set", 32'(rd_data), 32'h18);
    wr_reg(8'h00);
    chk("R6 no pulse holds", 32'(dma_wr), 32'h1);
    chk("R8 readback held", 32'(rd_data), 32'h08);
    wr_reg(8'h08);
    chk("R6 clear", 32'(dma_wr), 32'h0);
    chk("R8 readback clear", 32'(rd_data), 32'h00);
  endtask

  task automatic t_same_write;
    wr_reg(8'h18);
    chk("R7 old master 0", 32'(dma_wr), 32'h0);
    wr_reg(8'h08);
    chk("R7 old master 1", 32'(dma_wr), 32'h1);
    wr_reg(8'h00);
  endtask

  task automatic t_prio;
    load_addr(32'h0000_0020);
    wr_reg(8'h80);
    addr_load = 1'b1; addr_load_val = 32'h0000_0050;
    @(negedge clk);
    addr_load = 1'b0;
    chk("R9 load beats step", next_addr, 32'h0000_0050);
    load_cnt(24'd9);
    wr_reg(8'h40);
    cnt_load = 1'b1; cnt_load_val = 24'd3;
    @(negedge clk);
    cnt_load = 1'b0;
    chk("R9 cnt load beats step", 32'(byte_cnt), 32'd3);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_fields();
    t_addr();
    t_cnt();
    t_dir();
    t_same_write();
    t_prio();
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule